// File: doc/BRIEF.md
# Vector Rotate-Under-Mask Unit

The unit carries out one rotate-under-mask operation on 128-bit vector operands in a single registered step. An instruction word picks the lane width (four 32-bit word lanes or two 64-bit doubleword lanes) and the write mode. Each lane rotates its slice of the source operand A to the left. It then keeps only the bits inside a contiguous field whose limits, like the rotate amount, come from small fields inside the matching slice of the control operand B.

In mask-only mode the bits outside the field are cleared. In insert mode those bits are taken from the old destination operand T instead. If the field's start lies after its stop, the field wraps around the lane boundary.

An instruction word that does not name one of the four supported operations raises an illegal flag for one cycle instead of producing a result. The result and flags appear on the clock edge that follows the input strobe.

Top module: `vrm_unit`

## Requirements
- R1: An instruction word is legal only when bits [31:26] are 000100 and bits [10:0] are one of the following.
  - 00010000101: word lanes, insert mode.
  - 00011000101: doubleword lanes, insert mode.
  - 00110000101: word lanes, mask-only mode.
  - 00111000101: doubleword lanes, mask-only mode.
- R2: When an illegal instruction word is strobed, the next cycle shows out_illegal high, out_valid low and result zero. Both flags drop again in the cycle after that, unless a new strobe arrives.
- R3: After a legal strobe, result and out_valid=1 appear one clock later. In a cycle with no strobe, both flags are low in the following cycle and result keeps its previous value.
- R4: Within each lane of B, the fields are counted from the lane's least significant bit:
  - bits [5:0] are the rotate count;
  - bits [13:8] are the field stop;
  - bits [21:16] are the field start.
  Each field is reduced modulo the lane width (32 or 64), and all other bits of B are ignored.
- R5: Each lane of A is rotated left by its own count within the lane width, and no bit moves between lanes.
- R6: When start is less than or equal to stop, the mask covers bit positions start through stop. Positions are numbered from 0 at the most significant bit of the lane, so start equal to stop selects a single bit.
- R7: When start is greater than stop, the mask covers the positions from start to the end of the lane and from 0 to stop, so it wraps around.
- R8: Mask-only mode writes the rotated value ANDed with the mask. Insert mode writes the rotated value where the mask is set and the T bit where it is clear.
- R9: A synchronous active-high reset clears result, out_valid and out_illegal on the next clock edge.
- R10: Bits [25:11] of the instruction word have no effect on the result or on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: the operands and the instruction word are valid |
| insn | input | 32 | Instruction word selecting lane width and mode |
| src_a | input | 128 | Rotate source |
| src_b | input | 128 | Per-lane control fields |
| src_t | input | 128 | Old destination, merged in insert mode |
| out_valid | output | 1 | Result valid, one cycle after a legal strobe |
| out_illegal | output | 1 | Illegal instruction word seen, one cycle after the strobe |
| result | output | 128 | Registered result |

## Verification
The bench builds the unit with the default vector width of 128 bits, so both lane layouts are live: four word lanes and two doubleword lanes. With different rotate counts and mask limits in neighbouring lanes, a bit leaking across a lane boundary, or a lane width picked wrongly, shows up as a wrong result. At this width the field-truncation cases differ between lane sizes. A count of 33, for example, means 1 in a word lane and 33 in a doubleword lane, and the bench checks both widths.

// File: rtl/vrm_pkg.sv
package vrm_pkg;

    localparam int VEC_W_DEF = 128;
    localparam int INSN_W    = 32;
    localparam int WORD_W    = 32;
    localparam int DWORD_W   = 64;

    localparam int PRIM_HI   = 31;
    localparam int PRIM_LO   = 26;
    localparam int SUB_W     = 11;

    localparam logic [PRIM_HI-PRIM_LO:0] PRIM_CODE = 6'b000100;
    localparam logic [SUB_W-1:0] SUB_W_INS  = 11'b00010000101;
    localparam logic [SUB_W-1:0] SUB_D_INS  = 11'b00011000101;
    localparam logic [SUB_W-1:0] SUB_W_MSK  = 11'b00110000101;
    localparam logic [SUB_W-1:0] SUB_D_MSK  = 11'b00111000101;

    localparam int CNT_LSB   = 0;
    localparam int STOP_LSB  = 8;
    localparam int START_LSB = 16;

    typedef struct packed {
        logic legal;
        logic dword;
        logic insert;
    } dec_t;

endpackage

// File: rtl/vrm_decode.sv
module vrm_decode
    import vrm_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [PRIM_HI-PRIM_LO:0] prim;
    logic [SUB_W-1:0]         sub;
    logic                     unused_fields;

    assign prim          = insn[PRIM_HI:PRIM_LO];
    assign sub           = insn[SUB_W-1:0];
    assign unused_fields = ^insn[PRIM_LO-1:SUB_W];

    always_comb begin
        dec = '0;
        if (prim == PRIM_CODE) begin
            unique case (sub)
                SUB_W_INS: dec = '{legal: 1'b1, dword: 1'b0, insert: 1'b1};
                SUB_D_INS: dec = '{legal: 1'b1, dword: 1'b1, insert: 1'b1};
                SUB_W_MSK: dec = '{legal: 1'b1, dword: 1'b0, insert: 1'b0};
                SUB_D_MSK: dec = '{legal: 1'b1, dword: 1'b1, insert: 1'b0};
                default:   dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/vrm_mask.sv
module vrm_mask #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [SW-1:0] start_pos,
    input  logic [SW-1:0] stop_pos,
    output logic [W-1:0]  mask
);
    logic [W-1:0] ones;
    logic [W-1:0] from_start;
    logic [W-1:0] past_stop;
    logic [W-1:0] span;

    always_comb begin
        ones       = '1;
        from_start = ones >> start_pos;
        past_stop  = (ones >> stop_pos) >> 1;
        span       = from_start ^ past_stop;
        mask       = (start_pos > stop_pos) ? ~span : span;
    end
endmodule

// File: rtl/vrm_lane.sv
module vrm_lane
    import vrm_pkg::*;
#(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] t,
    input  logic         insert,
    output logic [W-1:0] r
);
    logic [SW-1:0]  amt;
    logic [SW-1:0]  stop_pos;
    logic [SW-1:0]  start_pos;
    logic [2*W-1:0] doubled;
    logic [W-1:0]   rotated;
    logic [W-1:0]   mask;
    logic           unused_ctrl;

    assign amt         = b[CNT_LSB +: SW];
    assign stop_pos    = b[STOP_LSB +: SW];
    assign start_pos   = b[START_LSB +: SW];
    assign unused_ctrl = ^{b[W-1:START_LSB+SW], b[START_LSB-1:STOP_LSB+SW],
                           b[STOP_LSB-1:CNT_LSB+SW]};

    always_comb begin
        doubled = {a, a} << amt;
        rotated = doubled[2*W-1:W];
    end

    vrm_mask #(.W(W)) u_mask (
        .start_pos (start_pos),
        .stop_pos  (stop_pos),
        .mask      (mask)
    );

    always_comb begin
        if (insert) begin
            r = (rotated & mask) | (t & ~mask);
        end else begin
            r = rotated & mask;
        end
    end
endmodule

// File: rtl/vrm_unit.sv
module vrm_unit
    import vrm_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF,
    localparam int N_WORD  = VEC_W / WORD_W,
    localparam int N_DWORD = VEC_W / DWORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  src_t,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [VEC_W-1:0]  result
);
    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] data;
    } st_t;

    st_t              st_d;
    st_t              st_q;
    dec_t             dec;
    logic [VEC_W-1:0] res_word;
    logic [VEC_W-1:0] res_dword;

    vrm_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    for (genvar g = 0; g < N_WORD; g++) begin : g_word
        vrm_lane #(.W(WORD_W)) u_lane (
            .a      (src_a[g*WORD_W +: WORD_W]),
            .b      (src_b[g*WORD_W +: WORD_W]),
            .t      (src_t[g*WORD_W +: WORD_W]),
            .insert (dec.insert),
            .r      (res_word[g*WORD_W +: WORD_W])
        );
    end

    for (genvar g = 0; g < N_DWORD; g++) begin : g_dword
        vrm_lane #(.W(DWORD_W)) u_lane (
            .a      (src_a[g*DWORD_W +: DWORD_W]),
            .b      (src_b[g*DWORD_W +: DWORD_W]),
            .t      (src_t[g*DWORD_W +: DWORD_W]),
            .insert (dec.insert),
            .r      (res_dword[g*DWORD_W +: DWORD_W])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.illegal = 1'b0;
        if (in_valid) begin
            if (dec.legal) begin
                st_d.valid = 1'b1;
                st_d.data  = dec.dword ? res_dword : res_word;
            end else begin
                st_d.illegal = 1'b1;
                st_d.data    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign result      = st_q.data;
endmodule

// File: rtl/vrm_unit_chk.sv
module vrm_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      insn,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [VEC_W-1:0] result
);
    // R2, R3: the two flags never rise together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    // R2: an illegal report carries a zero result
    a_r2_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (result == '0));

    // R2, R1: wrong primary field is reported as illegal next cycle
    a_r2_bad_primary: assert property (@(posedge clk) disable iff (rst)
        (in_valid && insn[31:26] != 6'b000100) |=> (out_illegal && !out_valid));

    // R3: no strobe means quiet flags and a held result
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && $stable(result)));

    // R3: a strobe always yields exactly one of the two flags
    a_r3_strobe_answered: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid || out_illegal));

    // R9: reset clears everything on the next edge
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && result == '0));
endmodule

bind vrm_unit vrm_unit_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/vrm_unit_bench.sv
module vrm_unit_bench;
    localparam int VW = 128;
    localparam logic [31:0] OP_WI = 32'h1000_0085;
    localparam logic [31:0] OP_DI = 32'h1000_00C5;
    localparam logic [31:0] OP_WM = 32'h1000_0185;
    localparam logic [31:0] OP_DM = 32'h1000_01C5;

    typedef struct packed {
        logic [31:0]   insn;
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        logic [VW-1:0] t;
    } vec_t;

    localparam int NTBL = 6;
    localparam vec_t TBL [NTBL] = '{
        '{OP_WM, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                 128'h0000_1F00_0010_1704_0003_0C05_001C_0301, 128'h0},
        '{OP_WI, 128'hFFFF_0000_AAAA_5555_8000_0001_0F0F_F0F0,
                 128'h0004_0808_001F_0000_0008_0404_0010_0F1F,
                 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978},
        '{OP_DM, 128'hDEAD_BEEF_0000_0001_8000_0000_0000_0001,
                 128'h0000_0000_0020_3F04_0000_0000_0000_3F3F, 128'h0},
        '{OP_DI, 128'hFFFF_FFFF_FFFF_FFFF_0123_4567_89AB_CDEF,
                 128'h0000_0000_0030_0F00_0000_0000_0008_1020,
                 128'h5555_5555_5555_5555_AAAA_AAAA_AAAA_AAAA},
        '{OP_WM, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
                 128'h0000_0000_0000_1F00_001F_0000_000A_0A00, 128'h0},
        '{OP_DM, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
                 128'h003F_0000_0000_0000_0000_0000_0028_1000, 128'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   insn = '0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [VW-1:0] src_t = '0;
    logic          out_valid;
    logic          out_illegal;
    logic [VW-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    vrm_unit u_vrm_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .insn        (insn),
        .src_a       (src_a),
        .src_b       (src_b),
        .src_t       (src_t),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .result      (result)
    );

    // Bitwise reference: returns legality through 'ok'
    function automatic logic [VW-1:0] model(input logic [31:0] op, input logic [VW-1:0] a,
                                            input logic [VW-1:0] b, input logic [VW-1:0] t,
                                            output bit ok);
        logic [VW-1:0] o;
        logic [10:0]   sub;
        int w;
        bit ins;
        o   = '0;
        sub = op[10:0];
        ok  = (op[31:26] == 6'b000100) &&
              (sub == 11'h085 || sub == 11'h0C5 || sub == 11'h185 || sub == 11'h1C5);
        if (!ok) return '0;
        w   = (sub == 11'h0C5 || sub == 11'h1C5) ? 64 : 32;
        ins = (sub == 11'h085 || sub == 11'h0C5);
        for (int ln = 0; ln < VW / w; ln++) begin
            int base, n, bg, en;
            base = ln * w;
            n  = int'(b[base +: 6]) % w;
            en = int'(b[base + 8 +: 6]) % w;
            bg = int'(b[base + 16 +: 6]) % w;
            for (int i = 0; i < w; i++) begin
                int p, src;
                bit inm;
                p   = w - 1 - i;
                inm = (bg <= en) ? (p >= bg && p <= en) : (p >= bg || p <= en);
                src = (i - n + w) % w;
                if (inm) o[base + i] = a[base + src];
                else if (ins) o[base + i] = t[base + i];
            end
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] op, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input logic [VW-1:0] t);
        @(negedge clk);
        in_valid = 1'b1;
        insn  = op;
        src_a = a;
        src_b = b;
        src_t = t;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_model(input string req, input logic [31:0] op, input logic [VW-1:0] a,
                             input logic [VW-1:0] b, input logic [VW-1:0] t);
        logic [VW-1:0] e;
        bit ok;
        e = model(op, a, b, t, ok);
        issue(op, a, b, t);
        check(req, result, e);
        check(req, {127'b0, out_valid}, {127'b0, ok});
        check(req, {127'b0, out_illegal}, {127'b0, !ok});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] held;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset result", result, '0);
        check("R9 reset flags", {126'b0, out_valid, out_illegal}, '0);
        rst = 1'b0;

        for (int k = 0; k < NTBL; k++) begin
            run_model("R8 table", TBL[k].insn, TBL[k].a, TBL[k].b, TBL[k].t);
        end

        // R5 R6: word lane, count 8, start 16, stop 23
        issue(OP_WM, {4{32'h0000_00FF}}, {4{32'h0010_1708}}, '0);
        check("R6 span", result, {4{32'h0000_FF00}});
        check("R3 valid", {127'b0, out_valid}, 128'd1);

        // R6: start equal to stop selects one bit
        issue(OP_WM, {4{32'hFFFF_FFFF}}, {4{32'h0000_0000}}, '0);
        check("R6 single bit", result, {4{32'h8000_0000}});

        // R7: wrap with start 28 stop 3, mask-only then insert
        issue(OP_WM, {4{32'hFFFF_FFFF}}, {4{32'h001C_0300}}, '0);
        check("R7 wrap", result, {4{32'hF000_000F}});
        issue(OP_WI, {4{32'hFFFF_FFFF}}, {4{32'h001C_0300}}, {4{32'h1234_5678}});
        check("R8 insert wrap", result, {4{32'hF234_567F}});

        // R4: bits outside the fields set, count 33 means 1 in a word lane
        issue(OP_WM, {4{32'h8000_0001}}, {4{32'hFFC0_DFE1}}, '0);
        check("R4 truncation", result, {4{32'h0000_0003}});

        // R5: doubleword rotate keeps bits inside each 64-bit lane
        issue(OP_DM, {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001},
              {2{64'h0000_0000_0000_3F01}}, '0);
        check("R5 dword lanes", result, {64'h0000_0000_0000_0003, 64'h0000_0000_0000_0002});
        // R4: count 33 in a doubleword lane is kept
        issue(OP_DM, {2{64'h0000_0000_0000_0001}}, {2{64'h0000_0000_0000_3F21}}, '0);
        check("R4 dword count", result, {2{64'h0000_0002_0000_0000}});

        // R3: idle cycle holds result and drops flags
        held = result;
        @(negedge clk);
        check("R3 hold", result, held);
        check("R3 idle flags", {126'b0, out_valid, out_illegal}, '0);

        // R2: bad primary and bad sub-opcode
        issue(32'h1400_0085, {4{32'hFFFF_FFFF}}, '0, '0);
        check("R2 bad primary result", result, '0);
        check("R2 bad primary flags", {126'b0, out_valid, out_illegal}, 128'd1);
        @(negedge clk);
        check("R2 one cycle", {126'b0, out_valid, out_illegal}, '0);
        issue(32'h1000_0084, {4{32'hFFFF_FFFF}}, '0, '0);
        check("R1 bad sub flags", {126'b0, out_valid, out_illegal}, 128'd1);

        // R10: register fields in bits 25:11 do not matter
        issue(OP_WM | 32'h03FF_F800, {4{32'h0000_00FF}}, {4{32'h0010_1708}}, '0);
        check("R10 ignored fields", result, {4{32'h0000_FF00}});
        check("R10 valid", {127'b0, out_valid}, 128'd1);

        // R1 R8: random stimulus against the reference
        for (int k = 0; k < 200; k++) begin
            logic [31:0] op;
            logic [VW-1:0] a, b, t;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            t = {$urandom, $urandom, $urandom, $urandom};
            case ($urandom % 5)
                0: op = OP_WI;
                1: op = OP_DI;
                2: op = OP_WM;
                3: op = OP_DM;
                default: op = $urandom;
            endcase
            op[25:11] = 15'($urandom);
            run_model("R1 random", op, a, b, t);
        end

        // R9: reset in mid-run clears a held result
        issue(OP_WM, {4{32'hFFFF_FFFF}}, {4{32'h0000_1F00}}, '0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset", result, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule